// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind one byte-wide host port. The host writes a control byte to choose a channel, how that channel's 16-bit values travel over the 8-bit port, and how the channel counts. It then writes the reload value one byte at a time. After that the channel counts down once on every cycle where the shared tick enable is high. The host can capture a channel's running count into a read latch at any time and read that latch back one byte per access.

Two counting behaviours are built. The first is a one-shot terminal-count mode. Its output stays low until the count runs out, then stays high. The second is a periodic divider. It reloads itself and drops its output for one count period in every cycle of the period. Each channel also has a one-cycle pulse that marks every change of its output level, so channel 0 can drive an interrupt request line directly. Each channel has a gate input that only pauses counting.

Host address map: offsets 0 to 2 reach the data port of channels 0 to 2, and offset 3 takes control bytes. A read returns its byte on `rd_data` in the cycle after the read strobe.

Top module: `pit_timer`

## Requirements
- R1: After reset, every output pin is low, `chg_pulse` and `rd_data` are zero, and every channel uses low-then-high byte access with a count and latch of 0.
- R2: In a control byte, bits 7:6 pick the channel. The value 3 in that field changes nothing in any channel.
- R3: Control bits 5:4 set the byte access: 1 means the low byte only, 2 means the high byte only, 3 means the low byte and then the high byte. A single-byte data write replaces only that byte of the reload value and keeps the other byte.
- R4: In low-then-high access, the first data write stores the low byte and the second stores the high byte and loads the counter. Every control byte with nonzero bits 5:4 resets the byte order, so the next access is a low byte.
- R5: Control bits 3:1 pick the counting behaviour: 0 selects terminal count, 2 or 6 selects the periodic divider, and any other code leaves the channel not counting with its output high. Bit 0 has no effect.
- R6: A control byte with nonzero bits 5:4 freezes the counter until the reload value is complete. It drives the output low for terminal count and high for every other code.
- R7: In terminal count, each tick subtracts 1 in binary. The tick taken at count 1 raises the output, which then stays high while the count wraps past zero to 0xFFFF without reloading.
- R8: In the periodic divider, a tick at count 1 loads the reload value instead of reaching 0. The output is low exactly while the count is 1.
- R9: A channel whose gate input is high does not count.
- R10: A control byte with bits 5:4 equal to 0 copies the channel's count into its read latch. It leaves the access mode, the counting behaviour and the byte order unchanged.
- R11: A data read returns a byte of the latch: the low byte in low-only access, the high byte in high-only access. In low-then-high access it returns the low byte, then the high byte, sharing the byte order with data writes.
- R12: `chg_pulse[i]` is high for exactly one cycle, in the same cycle that `tmr_out[i]` takes a new level.
- R13: When a data write completes the reload in a tick cycle, the counter takes the reload value with no decrement. A count-capture command in a tick cycle captures the count from before that tick.
- R14: All channels count on the same tick, each from its own state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Byte returned by the previous read |
| tick_en | input | 1 | Shared count enable, one tick per high cycle |
| gate | input | 3 | Per-channel count pause |
| tmr_out | output | 3 | Per-channel output level |
| chg_pulse | output | 3 | Per-channel one-cycle output-change flag |

## Verification
Host traffic and counting can land on the same clock edge, and the block must order them correctly. The bench drives a closing high-byte reload write in a cycle where the tick enable is also high, and expects the captured count to equal the reload value untouched. It then raises a count-capture command together with a tick, and expects the latch to hold the count from before the tick while a later capture shows it one lower. In the same way, gate and tick overlap for several cycles, and the count read afterwards must not have moved.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int SEL_W = 2;

    // byte access field of a control byte
    typedef enum logic [1:0] {
        ACC_CAPTURE = 2'd0,
        ACC_LO      = 2'd1,
        ACC_HI      = 2'd2,
        ACC_LOHI    = 2'd3
    } acc_e;

    // counting behaviour after decode
    typedef enum logic [1:0] {
        OP_TERM = 2'd0,
        OP_RATE = 2'd1,
        OP_IDLE = 2'd2
    } op_e;

    function automatic op_e op_decode(input logic [2:0] code);
        case (code)
            3'd0:       return OP_TERM;
            3'd2, 3'd6: return OP_RATE;
            default:    return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pit_host_dec.sv
module pit_host_dec
    import pit_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int ADDR_W = 2
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:1]        cw,
    output logic [N_CH-1:0]   mode_we,
    output logic [N_CH-1:0]   cap_we,
    output logic [N_CH-1:0]   dat_we,
    output logic [N_CH-1:0]   dat_re,
    output acc_e              cw_acc,
    output op_e               cw_op
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_CH);

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (addr == CTRL_ADDR);
    assign cw_acc   = acc_e'(cw[5:4]);
    assign cw_op    = op_decode(cw[3:1]);

    for (genvar i = 0; i < N_CH; i++) begin : g_dec
        logic sel_hit;
        assign sel_hit    = ctrl_hit && (cw[7:6] == SEL_W'(i));
        assign mode_we[i] = sel_hit && (cw_acc != ACC_CAPTURE);
        assign cap_we[i]  = sel_hit && (cw_acc == ACC_CAPTURE);
        assign dat_we[i]  = wr_en && (addr == ADDR_W'(i));
        assign dat_re[i]  = rd_en && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic              cap_we,
    input  acc_e              cw_acc,
    input  op_e               cw_op,
    input  logic              dat_we,
    input  logic              dat_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick_en,
    input  logic              gate,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              out_lvl,
    output logic              out_chg,
    output logic [CNT_W-1:0]  cnt_obs,
    output op_e               op_obs,
    output logic              hold_obs,
    output logic              step_obs
);
    acc_e             acc_q;
    op_e              op_q;
    logic             tog_q, hold_q, out_q, chg_q;
    logic [CNT_W-1:0] cnt_q, rel_q, lat_q;

    logic [CNT_W-1:0] rel_d, cnt_step;
    logic             tog_d, load_done, step, out_step, out_d;

    // byte-wise reload assembly and the shared byte order
    always_comb begin
        rel_d     = rel_q;
        tog_d     = tog_q;
        load_done = 1'b0;
        if (dat_we) begin
            case (acc_q)
                ACC_LO: begin
                    rel_d[BYTE_W-1:0] = wdata;
                    load_done         = 1'b1;
                end
                ACC_HI: begin
                    rel_d[CNT_W-1:BYTE_W] = wdata;
                    load_done             = 1'b1;
                end
                default: begin
                    if (!tog_q) begin
                        rel_d[BYTE_W-1:0] = wdata;
                        tog_d             = 1'b1;
                    end else begin
                        rel_d[CNT_W-1:BYTE_W] = wdata;
                        tog_d                 = 1'b0;
                        load_done             = 1'b1;
                    end
                end
            endcase
        end else if (dat_re && acc_q == ACC_LOHI) begin
            tog_d = !tog_q;
        end
    end

    assign step = tick_en && !gate && !hold_q && (op_q != OP_IDLE)
                  && !mode_we && !load_done;

    // one count step for the active behaviour
    always_comb begin
        out_step = out_q;
        if (op_q == OP_TERM) begin
            cnt_step = cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) out_step = 1'b1;
        end else begin
            cnt_step = (cnt_q == CNT_W'(1)) ? rel_q : cnt_q - CNT_W'(1);
            out_step = (cnt_step != CNT_W'(1));
        end
    end

    always_comb begin
        out_d = out_q;
        if (mode_we)   out_d = (cw_op != OP_TERM);
        else if (step) out_d = out_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= ACC_LOHI;
            op_q   <= OP_TERM;
            tog_q  <= 1'b0;
            hold_q <= 1'b1;
            out_q  <= 1'b0;
            chg_q  <= 1'b0;
            cnt_q  <= '0;
            rel_q  <= '0;
            lat_q  <= '0;
        end else begin
            out_q <= out_d;
            chg_q <= (out_d != out_q);
            if (cap_we) lat_q <= cnt_q;
            if (mode_we) begin
                acc_q  <= cw_acc;
                op_q   <= cw_op;
                tog_q  <= 1'b0;
                hold_q <= 1'b1;
            end else begin
                tog_q <= tog_d;
                rel_q <= rel_d;
                if (load_done) begin
                    hold_q <= 1'b0;
                    cnt_q  <= rel_d;
                end else if (step) begin
                    cnt_q <= cnt_step;
                end
            end
        end
    end

    always_comb begin
        case (acc_q)
            ACC_HI:   rd_byte = lat_q[CNT_W-1:BYTE_W];
            ACC_LOHI: rd_byte = tog_q ? lat_q[CNT_W-1:BYTE_W] : lat_q[BYTE_W-1:0];
            default:  rd_byte = lat_q[BYTE_W-1:0];
        endcase
    end

    assign out_lvl  = out_q;
    assign out_chg  = chg_q;
    assign cnt_obs  = cnt_q;
    assign op_obs   = op_q;
    assign hold_obs = hold_q;
    assign step_obs = step;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              tick_en,
    input  logic [N_CH-1:0]   gate,
    output logic [N_CH-1:0]   tmr_out,
    output logic [N_CH-1:0]   chg_pulse
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [N_CH-1:0]             mode_we, cap_we, dat_we, dat_re;
    acc_e                        cw_acc;
    op_e                         cw_op;
    logic [N_CH-1:0][BYTE_W-1:0] rd_byte;
    logic [N_CH-1:0][CNT_W-1:0]  cnt_obs;
    logic [N_CH-1:0]             is_term, is_rate, hold_obs, step_obs;

    pit_host_dec #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .cw      (wr_data[7:1]),
        .mode_we (mode_we),
        .cap_we  (cap_we),
        .dat_we  (dat_we),
        .dat_re  (dat_re),
        .cw_acc  (cw_acc),
        .cw_op   (cw_op)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        op_e op_i;
        pit_channel #(.BYTE_W(BYTE_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .mode_we  (mode_we[i]),
            .cap_we   (cap_we[i]),
            .cw_acc   (cw_acc),
            .cw_op    (cw_op),
            .dat_we   (dat_we[i]),
            .dat_re   (dat_re[i]),
            .wdata    (wr_data),
            .tick_en  (tick_en),
            .gate     (gate[i]),
            .rd_byte  (rd_byte[i]),
            .out_lvl  (tmr_out[i]),
            .out_chg  (chg_pulse[i]),
            .cnt_obs  (cnt_obs[i]),
            .op_obs   (op_i),
            .hold_obs (hold_obs[i]),
            .step_obs (step_obs[i])
        );
        assign is_term[i] = (op_i == OP_TERM);
        assign is_rate[i] = (op_i == OP_RATE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            for (int i = 0; i < N_CH; i++) begin
                if (addr == ADDR_W'(i)) rd_data <= rd_byte[i];
            end
        end
    end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int N_CH   = 3,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [N_CH-1:0]            gate,
    input logic [N_CH-1:0]            tmr_out,
    input logic [N_CH-1:0]            chg_pulse,
    input logic [N_CH-1:0][CNT_W-1:0] cnt_obs,
    input logic [N_CH-1:0]            is_term,
    input logic [N_CH-1:0]            is_rate,
    input logic [N_CH-1:0]            hold_obs,
    input logic [N_CH-1:0]            step_obs
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_CH);

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        logic own_wr, ctl_wr;
        assign own_wr = wr_en && (addr == ADDR_W'(i));
        assign ctl_wr = wr_en && (addr == CTRL_ADDR);

        // R12
        chg_marks_edge_chk: assert property (@(posedge clk) disable iff (rst)
            chg_pulse[i] == (tmr_out[i] != $past(tmr_out[i])));

        // R9
        gate_freeze_chk: assert property (@(posedge clk) disable iff (rst)
            gate[i] && !own_wr && !ctl_wr |=> $stable(cnt_obs[i]));

        // R6
        hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
            hold_obs[i] && !own_wr |=> $stable(cnt_obs[i]));

        // R8
        rate_low_at_one_chk: assert property (@(posedge clk) disable iff (rst)
            is_rate[i] && step_obs[i] |=> tmr_out[i] == (cnt_obs[i] == CNT_W'(1) ? 1'b0 : 1'b1));

        // R7
        term_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            is_term[i] && tmr_out[i] && !ctl_wr |=> tmr_out[i]);
    end
endmodule

bind pit_timer pit_timer_chk #(.N_CH(N_CH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .gate      (gate),
    .tmr_out   (tmr_out),
    .chg_pulse (chg_pulse),
    .cnt_obs   (cnt_obs),
    .is_term   (is_term),
    .is_rate   (is_rate),
    .hold_obs  (hold_obs),
    .step_obs  (step_obs)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, tick_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] gate = '0;
    logic [7:0] rd_data;
    logic [2:0] tmr_out, chg_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pit_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .tick_en(tick_en), .gate(gate),
        .tmr_out(tmr_out), .chg_pulse(chg_pulse)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; b = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic get_cnt(input logic [1:0] ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(2'd3, {ch, 6'b0});
        rd(ch, lo);
        rd(ch, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 out", 16'(tmr_out), 16'h0);
        check("R1 chg", 16'(chg_pulse), 16'h0);
        check("R1 rdata", 16'(rd_data), 16'h0);
        get_cnt(2'd0, v);
        check("R1 count", v, 16'h0);
    endtask

    task automatic t_term();
        logic [15:0] v;
        wr(2'd3, 8'h30);
        check("R6 term out low", 16'(tmr_out[0]), 16'h0);
        wr(2'd0, 8'h05);
        ticks(3);
        wr(2'd0, 8'h00);
        get_cnt(2'd0, v);
        check("R4 R6 held then loaded", v, 16'h0005);
        ticks(4);
        get_cnt(2'd0, v);
        check("R7 count", v, 16'h0001);
        check("R7 out before end", 16'(tmr_out[0]), 16'h0);
        ticks(1);
        check("R7 out rises", 16'(tmr_out[0]), 16'h1);
        check("R12 pulse", 16'(chg_pulse[0]), 16'h1);
        @(negedge clk);
        check("R12 pulse one cycle", 16'(chg_pulse[0]), 16'h0);
        ticks(2);
        get_cnt(2'd0, v);
        check("R7 wrap", v, 16'hFFFE);
        check("R7 stays high", 16'(tmr_out[0]), 16'h1);
    endtask

    task automatic t_rate();
        logic [15:0] v;
        wr(2'd3, 8'h74);
        check("R6 rate out high", 16'(tmr_out[1]), 16'h1);
        wr(2'd1, 8'h03);
        wr(2'd1, 8'h00);
        ticks(1);
        check("R8 at 2", 16'(tmr_out[1]), 16'h1);
        ticks(1);
        check("R8 low at 1", 16'(tmr_out[1]), 16'h0);
        check("R12 fall pulse", 16'(chg_pulse[1]), 16'h1);
        ticks(1);
        check("R8 high after reload", 16'(tmr_out[1]), 16'h1);
        check("R12 rise pulse", 16'(chg_pulse[1]), 16'h1);
        get_cnt(2'd1, v);
        check("R8 reloaded", v, 16'h0003);
        wr(2'd3, 8'h7C);
        check("R5 alias out high", 16'(tmr_out[1]), 16'h1);
        wr(2'd1, 8'h02);
        wr(2'd1, 8'h00);
        ticks(1);
        check("R5 alias low at 1", 16'(tmr_out[1]), 16'h0);
    endtask

    task automatic t_gate();
        logic [15:0] v;
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'd10);
        wr(2'd2, 8'h00);
        gate[2] = 1'b1;
        ticks(5);
        get_cnt(2'd2, v);
        check("R9 gated", v, 16'd10);
        gate[2] = 1'b0;
        ticks(3);
        get_cnt(2'd2, v);
        check("R9 resumed", v, 16'd7);
    endtask

    task automatic t_access();
        logic [7:0]  b;
        logic [15:0] v;
        wr(2'd3, 8'h90);
        wr(2'd2, 8'h34);
        wr(2'd3, 8'h80);
        rd(2'd2, b);
        check("R3 R11 low only", 16'(b), 16'h34);
        rd(2'd2, b);
        check("R11 low only again", 16'(b), 16'h34);
        wr(2'd3, 8'hA0);
        wr(2'd2, 8'h12);
        wr(2'd3, 8'h80);
        rd(2'd2, b);
        check("R3 R11 high only", 16'(b), 16'h12);
        wr(2'd3, 8'hB0);
        get_cnt(2'd2, v);
        check("R3 bytes kept", v, 16'h1234);
    endtask

    task automatic t_order();
        logic [7:0]  b;
        logic [15:0] v;
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h07);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h09);
        wr(2'd0, 8'h00);
        get_cnt(2'd0, v);
        check("R4 order reset by control", v, 16'h0009);
        wr(2'd3, 8'h00);
        rd(2'd0, b);
        check("R11 first low", 16'(b), 16'h09);
        wr(2'd3, 8'h30);
        wr(2'd3, 8'h00);
        rd(2'd0, b);
        check("R4 R11 low after control", 16'(b), 16'h09);
        rd(2'd0, b);
        check("R11 then high", 16'(b), 16'h00);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h20);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h00);
        rd(2'd0, b);
        check("R10 latch low", 16'(b), 16'h09);
        rd(2'd0, b);
        check("R10 latch high", 16'(b), 16'h00);
        get_cnt(2'd0, v);
        check("R10 order kept", v, 16'h0020);
    endtask

    task automatic t_readback();
        logic [15:0] v;
        wr(2'd3, 8'hFE);
        wr(2'd3, 8'hC0);
        ticks(1);
        get_cnt(2'd0, v);
        check("R2 field 3 ignored count", v, 16'h001F);
        check("R2 field 3 ignored out", 16'(tmr_out[0]), 16'h0);
    endtask

    task automatic t_idle();
        logic [15:0] v;
        wr(2'd3, 8'hB2);
        check("R5 other code out high", 16'(tmr_out[2]), 16'h1);
        wr(2'd2, 8'h05);
        wr(2'd2, 8'h00);
        ticks(3);
        get_cnt(2'd2, v);
        check("R5 other code no count", v, 16'h0005);
    endtask

    task automatic t_same_cycle();
        logic [7:0]  b;
        logic [15:0] v;
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h04);
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wr_data = 8'h00; tick_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
        get_cnt(2'd0, v);
        check("R13 load beats tick", v, 16'h0004);
        @(negedge clk); wr_en = 1'b1; addr = 2'd3; wr_data = 8'h00; tick_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
        rd(2'd0, b);
        check("R13 capture pre-tick low", 16'(b), 16'h04);
        rd(2'd0, b);
        check("R13 capture pre-tick high", 16'(b), 16'h00);
        get_cnt(2'd0, v);
        check("R13 tick still taken", v, 16'h0003);
    endtask

    task automatic t_binary();
        logic [15:0] v;
        wr(2'd3, 8'h71);
        wr(2'd1, 8'h10);
        wr(2'd1, 8'h00);
        ticks(6);
        get_cnt(2'd1, v);
        check("R5 R7 binary with bit0 set", v, 16'h000A);
    endtask

    task automatic t_shared();
        logic [15:0] v;
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h04);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h70);
        wr(2'd1, 8'h06);
        wr(2'd1, 8'h00);
        ticks(4);
        check("R14 ch0 done", 16'(tmr_out[0]), 16'h1);
        check("R14 ch1 running", 16'(tmr_out[1]), 16'h0);
        get_cnt(2'd1, v);
        check("R14 ch1 count", v, 16'h0002);
        get_cnt(2'd0, v);
        check("R14 ch0 count", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_term();
        t_rate();
        t_gate();
        t_access();
        t_order();
        t_readback();
        t_idle();
        t_same_cycle();
        t_binary();
        t_shared();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule